// File: doc/BRIEF.md
# Shuffle-Exchange Corner-Turn Switch

This block is a memoryless permutation network for transposing a data matrix that is spread across many devices. It links LANES input lanes to LANES output lanes, where LANES is a power of two. On each cycle a select word of log2(LANES) bits picks one of LANES fixed permutations. A source that drives row entries in step with the select value therefore delivers, after LANES consecutive select values, exactly one entry to every sink. Because the select is stepped through all values, each sink receives a whole column, though not in index order.

The network is a chain of log2(LANES) identical stages. In each stage a fixed perfect-shuffle wiring rotates the lane address left by one bit. A column of LANES/2 two-input swappers then follows, and all swappers in the column share a single select bit. Stage s is steered by select bit s, so the select word takes effect bit-reversed on the lane address. A parameter can remove the shuffle that sits in front of the first stage. The block is still a valid corner turner in that form, with its outputs in a rotated order. The inputs are captured in a register that has a clock enable, and the result appears one cycle later together with a valid flag.

Top module: `ct_corner_turn`

## Requirements
- R1: With the leading shuffle present (DROP_LEAD_SHUFFLE=0), input lane i, held in bits [i*DATA_W +: DATA_W] of in_data, appears on output lane j = i XOR bitrev(sel). Here bitrev reverses the log2(LANES) bits of the select word.
- R2: With DROP_LEAD_SHUFFLE=1, input lane i appears on output lane j = rotr(i) XOR bitrev(sel). rotr rotates the lane address right by one bit.
- R3: For any single select value, every output lane carries exactly one input lane, so the sum of all output words equals the sum of all input words modulo 2^DATA_W.
- R4: Over LANES consecutive cycles whose select values are all distinct, every input lane reaches every output lane exactly once.
- R5: out_valid equals in_valid of the previous cycle, and out_data shows the routing of the in_data and in_sel captured on that same earlier edge.
- R6: While in_valid is 0, in_data and in_sel are ignored: out_data keeps its previous value and out_valid is 0.
- R7: While rst_n is low, out_valid is 0 and out_data is all zeros.
- R8: A select word with only bit k set sends input lane 0 to output lane 2^(log2(LANES)-1-k).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised internally |
| in_valid | input | 1 | Capture enable for in_sel and in_data |
| in_sel | input | log2(LANES) | Permutation select word |
| in_data | input | LANES*DATA_W | Input lanes, lane k in bits [k*DATA_W +: DATA_W] |
| out_valid | output | 1 | in_valid delayed by one cycle |
| out_data | output | LANES*DATA_W | Permuted lanes, lane k in bits [k*DATA_W +: DATA_W] |

## Verification
A change of the select word and a hold of the captured data can arrive in the same cycle. This happens when in_valid drops while in_sel and in_data move to new values. If the enable were applied wrongly, the held lanes would be routed again under the new select. The bench provokes this by driving a fresh select and fresh data with in_valid low for two cycles after a full sweep. It then requires out_data to match, bit for bit, the last word routed under the old select. Full sweeps of the select word on an eight-lane instance with the leading shuffle and on a sixteen-lane instance without it check every route against the arithmetic mapping. Each output lane word carries its source lane number, so the bench can count coverage from the outputs alone.

// File: rtl/ct_pkg.sv
`timescale 1ns/1ps
package ct_pkg;

  // Reverse the low 'bits' bits of v.
  function automatic int ct_bitrev(input int v, input int bits);
    int r;
    r = 0;
    for (int b = 0; b < bits; b++) begin
      if (((v >> b) & 1) != 0) r = r | (1 << (bits - 1 - b));
    end
    return r;
  endfunction

  // Rotate the low 'bits' bits of v right by one position.
  function automatic int ct_rotr(input int v, input int bits);
    int m;
    m = (1 << bits) - 1;
    return ((v >> 1) | ((v & 1) << (bits - 1))) & m;
  endfunction

endpackage

// File: rtl/ct_rst_sync.sv
`timescale 1ns/1ps
module ct_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[1];

endmodule

// File: rtl/ct_shuffle.sv
`timescale 1ns/1ps
module ct_shuffle
  import ct_pkg::*;
#(
  parameter int LANES  = 8,
  parameter int DATA_W = 16
) (
  input  logic [LANES*DATA_W-1:0] d_i,
  output logic [LANES*DATA_W-1:0] q_o
);

  localparam int ADDR_W = $clog2(LANES);

  // Lane j moves to rotl(j); so position k takes lane rotr(k).
  for (genvar k = 0; k < LANES; k++) begin : g_wire
    localparam int SRC = ct_rotr(k, ADDR_W);
    assign q_o[k*DATA_W +: DATA_W] = d_i[SRC*DATA_W +: DATA_W];
  end

endmodule

// File: rtl/ct_swap_col.sv
`timescale 1ns/1ps
module ct_swap_col #(
  parameter int LANES  = 8,
  parameter int DATA_W = 16
) (
  input  logic [LANES*DATA_W-1:0] d_i,
  input  logic                    swap_i,
  output logic [LANES*DATA_W-1:0] q_o
);

  localparam int PAIRS = LANES / 2;

  for (genvar m = 0; m < PAIRS; m++) begin : g_pair
    logic [DATA_W-1:0] even_w;
    logic [DATA_W-1:0] odd_w;
    assign even_w = d_i[(2*m)*DATA_W +: DATA_W];
    assign odd_w  = d_i[(2*m+1)*DATA_W +: DATA_W];
    assign q_o[(2*m)*DATA_W +: DATA_W]   = swap_i ? odd_w  : even_w;
    assign q_o[(2*m+1)*DATA_W +: DATA_W] = swap_i ? even_w : odd_w;
  end

endmodule

// File: rtl/ct_stage.sv
`timescale 1ns/1ps
module ct_stage #(
  parameter int LANES       = 8,
  parameter int DATA_W      = 16,
  parameter bit USE_SHUFFLE = 1'b1
) (
  input  logic [LANES*DATA_W-1:0] d_i,
  input  logic                    ctl_i,
  output logic [LANES*DATA_W-1:0] q_o
);

  logic [LANES*DATA_W-1:0] mid_w;

  if (USE_SHUFFLE) begin : g_shuf
    ct_shuffle #(.LANES(LANES), .DATA_W(DATA_W)) u_shuffle (
      .d_i (d_i),
      .q_o (mid_w)
    );
  end else begin : g_thru
    assign mid_w = d_i;
  end

  ct_swap_col #(.LANES(LANES), .DATA_W(DATA_W)) u_swap (
    .d_i    (mid_w),
    .swap_i (ctl_i),
    .q_o    (q_o)
  );

endmodule

// File: rtl/ct_corner_turn.sv
`timescale 1ns/1ps
module ct_corner_turn #(
  parameter int LANES             = 8,
  parameter int DATA_W            = 16,
  parameter bit DROP_LEAD_SHUFFLE = 1'b0
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             in_valid,
  input  logic [$clog2(LANES)-1:0]         in_sel,
  input  logic [LANES*DATA_W-1:0]          in_data,
  output logic                             out_valid,
  output logic [LANES*DATA_W-1:0]          out_data
);

  localparam int SEL_W = $clog2(LANES);
  localparam int BUS_W = LANES * DATA_W;

  logic rst_q_n;

  ct_rst_sync u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_q_n)
  );

  // Input capture: next-state logic
  logic [BUS_W-1:0] data_q, data_d;
  logic [SEL_W-1:0] sel_q,  sel_d;
  logic             vld_q,  vld_d;

  always_comb begin
    vld_d  = in_valid;
    data_d = data_q;
    sel_d  = sel_q;
    if (in_valid) begin
      data_d = in_data;
      sel_d  = in_sel;
    end
  end

  // Input capture: registers
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      data_q <= '0;
      sel_q  <= '0;
      vld_q  <= 1'b0;
    end else begin
      data_q <= data_d;
      sel_q  <= sel_d;
      vld_q  <= vld_d;
    end
  end

  // Stage chain: stage s steered by select bit s
  logic [BUS_W-1:0] bus_w [SEL_W+1];
  assign bus_w[0] = data_q;

  for (genvar s = 0; s < SEL_W; s++) begin : g_stage
    localparam bit SHUF = !(DROP_LEAD_SHUFFLE && (s == 0));
    ct_stage #(
      .LANES       (LANES),
      .DATA_W      (DATA_W),
      .USE_SHUFFLE (SHUF)
    ) u_stage (
      .d_i   (bus_w[s]),
      .ctl_i (sel_q[s]),
      .q_o   (bus_w[s+1])
    );
  end

  assign out_data  = bus_w[SEL_W];
  assign out_valid = vld_q;

endmodule

// File: rtl/ct_corner_turn_chk.sv
`timescale 1ns/1ps
module ct_corner_turn_chk
  import ct_pkg::*;
#(
  parameter int LANES             = 8,
  parameter int DATA_W            = 16,
  parameter bit DROP_LEAD_SHUFFLE = 1'b0
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       in_valid,
  input logic [$clog2(LANES)-1:0]   in_sel,
  input logic [LANES*DATA_W-1:0]    in_data,
  input logic                       out_valid,
  input logic [LANES*DATA_W-1:0]    out_data
);

  localparam int SEL_W = $clog2(LANES);

  function automatic logic [DATA_W-1:0] lane_sum(input logic [LANES*DATA_W-1:0] v);
    logic [DATA_W-1:0] acc;
    acc = '0;
    for (int k = 0; k < LANES; k++) acc = acc + v[k*DATA_W +: DATA_W];
    return acc;
  endfunction

  // Destination of input lane 0 (rotr of 0 is 0 in both variants)
  logic [SEL_W-1:0]  dst0_w, dst0_q;
  logic [DATA_W-1:0] picked_w;

  assign dst0_w = SEL_W'(ct_bitrev(int'(in_sel), SEL_W));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dst0_q <= '0;
    else        dst0_q <= dst0_w;
  end

  assign picked_w = out_data[int'(dst0_q)*DATA_W +: DATA_W];

  // R5: valid follows in_valid by one cycle
  a_r5_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r5_valid_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R6: no capture while in_valid is low
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_data));

  // R3: a permutation keeps the lane sum
  a_r3_sum_kept: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (lane_sum(out_data) == $past(lane_sum(in_data))));

  // R1 / R2: lane 0 lands on bitrev(sel)
  a_r1_lane0_route: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (picked_w == $past(in_data[DATA_W-1:0])));

endmodule

bind ct_corner_turn ct_corner_turn_chk #(
  .LANES             (LANES),
  .DATA_W            (DATA_W),
  .DROP_LEAD_SHUFFLE (DROP_LEAD_SHUFFLE)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_q_n),
  .in_valid  (in_valid),
  .in_sel    (in_sel),
  .in_data   (in_data),
  .out_valid (out_valid),
  .out_data  (out_data)
);

// File: tb/ct_corner_turn_bench.sv
`timescale 1ns/1ps
module ct_corner_turn_bench;

  localparam int DW = 16;
  localparam int NA = 8;
  localparam int NB = 16;

  logic clk;
  logic rst_n;
  logic in_valid;
  logic [2:0]        sel_a;
  logic [NA*DW-1:0]  data_a;
  logic              vld_a;
  logic [NA*DW-1:0]  out_a;
  logic [3:0]        sel_b;
  logic [NB*DW-1:0]  data_b;
  logic              vld_b;
  logic [NB*DW-1:0]  out_b;

  int checks;
  int fails;
  int cov_a [NA][NA];
  int cov_b [NB][NB];
  logic [NA*DW-1:0] last_a;
  logic [NB*DW-1:0] last_b;

  ct_corner_turn #(.LANES(NA), .DATA_W(DW), .DROP_LEAD_SHUFFLE(1'b0)) u_ct_corner_turn (
    .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_sel (sel_a),
    .in_data (data_a), .out_valid (vld_a), .out_data (out_a)
  );

  ct_corner_turn #(.LANES(NB), .DATA_W(DW), .DROP_LEAD_SHUFFLE(1'b1)) u_ct_corner_turn_b (
    .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_sel (sel_b),
    .in_data (data_b), .out_valid (vld_b), .out_data (out_b)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic int rev_bits(input int v, input int n);
    int r;
    r = 0;
    for (int b = 0; b < n; b++) if (((v >> b) & 1) != 0) r = r | (1 << (n - 1 - b));
    return r;
  endfunction

  function automatic int exp_dst(input int i, input int c, input int n, input bit drop);
    int a;
    a = i;
    if (drop) a = ((i >> 1) | ((i & 1) << (n - 1))) & ((1 << n) - 1);
    return a ^ rev_bits(c, n);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 20000, 0);
    summary();
    $finish;
  end

  initial begin
    checks = 0;
    fails  = 0;
    for (int x = 0; x < NB; x++) for (int y = 0; y < NB; y++) begin
      cov_b[x][y] = 0;
      if (x < NA && y < NA) cov_a[x][y] = 0;
    end
    rst_n = 1'b0; in_valid = 1'b0; sel_a = '0; sel_b = '0;
    data_a = '1; data_b = '1;
    repeat (3) @(negedge clk);
    // R7: reset state
    chk(vld_a == 1'b0 && vld_b == 1'b0, "R7 valid in reset", int'(vld_a), 0);
    chk(out_a == '0 && out_b == '0, "R7 data in reset", int'(out_a[15:0]), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Full sweep: R1, R2, R3, R4, R5, R8
    for (int step = 0; step < NB; step++) begin
      in_valid = 1'b1;
      sel_a = 3'(step);
      sel_b = 4'(step);
      for (int k = 0; k < NA; k++) data_a[k*DW +: DW] = {8'(step), 8'(k)};
      for (int k = 0; k < NB; k++) data_b[k*DW +: DW] = {8'(step + 64), 8'(k)};
      @(negedge clk);
      chk(vld_a && vld_b, "R5 valid one cycle later", int'(vld_a), 1);
      for (int i = 0; i < NA; i++) begin
        int j;
        j = exp_dst(i, step % NA, 3, 1'b0);
        chk(out_a[j*DW +: DW] == {8'(step), 8'(i)}, "R1 route",
            int'(out_a[j*DW +: DW]), int'({8'(step), 8'(i)}));
      end
      for (int i = 0; i < NB; i++) begin
        int j;
        j = exp_dst(i, step, 4, 1'b1);
        chk(out_b[j*DW +: DW] == {8'(step + 64), 8'(i)}, "R2 route",
            int'(out_b[j*DW +: DW]), int'({8'(step + 64), 8'(i)}));
      end
      // R3: every source id appears once per cycle (counted from outputs)
      if (step < NA) for (int j = 0; j < NA; j++) cov_a[int'(out_a[j*DW +: 8])][j]++;
      for (int j = 0; j < NB; j++) cov_b[int'(out_b[j*DW +: 8])][j]++;
      // R8: one-hot select bit k sends lane 0 to lane 2^(n-1-k)
      for (int k = 0; k < 4; k++) if (step == (1 << k)) begin
        chk(out_b[(1 << (3 - k))*DW +: 8] == 8'd0, "R8 one-hot bit",
            int'(out_b[(1 << (3 - k))*DW +: 8]), 0);
        if (k < 3)
          chk(out_a[(1 << (2 - k))*DW +: 8] == 8'd0, "R8 one-hot bit",
              int'(out_a[(1 << (2 - k))*DW +: 8]), 0);
      end
    end

    // R4 / R3: each source reached each sink exactly once
    for (int x = 0; x < NA; x++) for (int y = 0; y < NA; y++)
      chk(cov_a[x][y] == 1, "R4 coverage 8 lanes", cov_a[x][y], 1);
    for (int x = 0; x < NB; x++) for (int y = 0; y < NB; y++)
      chk(cov_b[x][y] == 1, "R4 coverage 16 lanes", cov_b[x][y], 1);

    // R6: new select and data with in_valid low are ignored
    last_a = out_a;
    last_b = out_b;
    for (int h = 0; h < 2; h++) begin
      in_valid = 1'b0;
      sel_a = 3'(h + 3);
      sel_b = 4'(h + 9);
      data_a = {NA{16'hA5A5}} ^ NA*DW'(h);
      data_b = {NB{16'h5A5A}} ^ NB*DW'(h);
      @(negedge clk);
      chk(!vld_a && !vld_b, "R6 valid low on hold", int'(vld_a), 0);
      chk(out_a == last_a, "R6 hold 8 lanes", int'(out_a[15:0]), int'(last_a[15:0]));
      chk(out_b == last_b, "R6 hold 16 lanes", int'(out_b[15:0]), int'(last_b[15:0]));
    end

    // R5: capture resumes with the next valid word
    in_valid = 1'b1;
    sel_a = 3'd6;
    for (int k = 0; k < NA; k++) data_a[k*DW +: DW] = {8'hEE, 8'(k)};
    @(negedge clk);
    in_valid = 1'b0;
    for (int i = 0; i < NA; i++) begin
      int j;
      j = exp_dst(i, 6, 3, 1'b0);
      chk(out_a[j*DW +: DW] == {8'hEE, 8'(i)}, "R5 resume route",
          int'(out_a[j*DW +: DW]), int'({8'hEE, 8'(i)}));
    end
    @(negedge clk);
    summary();
    $finish;
  end

endmodule